// File: doc/BRIEF.md
# UART Sample and Bit Rate Generator

This block turns a base clock source into the two timing strobes a UART needs: a per-sample tick and a per-bit tick. The base source is either a crystal reference or one of four alternate clocks. Each source is modelled as a clock-enable input inside one clock domain. The selected enable passes through a chain of three counters: a first prescaler (1 to 6), a second prescaler (1 to 6) and a 10-bit main divider. The output of that chain is the sample tick. An oversampling counter then groups the sample ticks into bits, with 1 to 63 samples per bit and a default of 16.

Software sets the block through two configuration words. The baud word carries the source choice, the alternate source index, both prescaler values and the main divider. The oversampling word carries the number of samples per bit. Writing either word restarts every counter, so the first tick after a write already follows the new settings. A transmitter and a receiver elsewhere consume the two ticks.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset both ticks are low. The defaults select the crystal, divide by 1 at every stage and use 16 samples per bit.
- R2: A sample tick is a one-cycle pulse. It appears in the cycle after the selected source enable that completes a group of first-prescaler × second-prescaler × main-divider enables, counted since reset or since the last configuration write.
- R3: The main divider is baud word bits [9:0]. A value of 0 acts as divide-by-1.
- R4: The first prescaler is baud word bits [17:15] and the second is bits [14:12]. A value of 0 acts as 1, and a value of 7 acts as 6.
- R5: Baud word bit 19 set selects the alternate source, and bits [11:10] then choose which of the four alternate enables counts. Bit 19 clear selects the crystal enable. Enables that are not selected have no effect on either tick.
- R6: Oversampling word bits [5:0] set the number of samples per bit (1 to 63). A value of 0 means 16. Bits [31:6] are ignored.
- R7: A bit tick is asserted only together with a sample tick, and it falls on the sample tick that completes each group of oversampling samples.
- R8: A write strobe for either word loads that word and clears all counters. Any source enable in the write cycle is dropped, and counting under the new settings starts in the next cycle.
- R9: Both ticks are low in the cycle after any configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudCfg | input | 32 | Baud configuration word |
| baudWr | input | 1 | Load strobe for baudCfg |
| osCfg | input | 32 | Oversampling configuration word |
| osWr | input | 1 | Load strobe for osCfg |
| xtalEn | input | 1 | Crystal reference clock enable |
| altEn | input | 4 | Alternate source clock enables |
| sampleTick | output | 1 | One-cycle pulse per sample |
| bitTick | output | 1 | One-cycle pulse per bit period |

## Verification
Both ticks are registered. Each one is due exactly one clock after the edge where the completing source enable, or a write, is seen. No other result exists. The bench drives inputs on the falling edge and updates a behavioural model. The model counts the selected enables against a single product period and counts the samples against the oversampling factor. On the next falling edge the bench compares the model with the outputs, so every cycle is checked at the point where its result is due. The cycle after each write carries an extra check that both ticks are low.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;
  localparam int CFG_W       = 32;
  localparam int DIV_W       = 10;
  localparam int PRE_W       = 3;
  localparam int PRE_MAX     = 6;
  localparam int OS_W        = 6;
  localparam int OS_DEFAULT  = 16;
  localparam int NUM_ALT     = 4;
  localparam int ALT_IDX_W   = $clog2(NUM_ALT);
  localparam int NUM_STAGES  = 3;

  localparam int DIV_LSB     = 0;
  localparam int ALT_IDX_LSB = 10;
  localparam int PRE2_LSB    = 12;
  localparam int PRE1_LSB    = 15;
  localparam int ALT_SEL_BIT = 19;

  typedef struct packed {
    logic clear;
    logic srcTick;
  } rate_strobe_t;
endpackage

// File: rtl/rate_div_stage.sv
module rate_div_stage #(
  parameter int W    = 10,
  parameter int MAXV = 1023
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inEn,
  input  logic [W-1:0] setting,
  output logic         outEn
);
  logic [W-1:0] count;
  logic [W-1:0] eff;
  logic         term;

  always_comb begin
    if (setting == '0)             eff = W'(1);
    else if (setting > W'(MAXV))   eff = W'(MAXV);
    else                           eff = setting;
  end

  assign term  = (count >= eff - W'(1));
  assign outEn = inEn & term;

  always_ff @(posedge clk) begin
    if (!rstN || clear) count <= '0;
    else if (inEn)      count <= term ? '0 : count + W'(1);
  end

  // R2 / R3 / R4: the stage counter stays inside its programmed period
  a_r3_count_in_period: assert property (@(posedge clk) disable iff (!rstN)
    count < eff);
endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import uart_rate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CFG_W-1:0]     baudCfg,
  input  logic                 baudWr,
  input  logic [CFG_W-1:0]     osCfg,
  input  logic                 osWr,
  input  logic                 xtalEn,
  input  logic [NUM_ALT-1:0]   altEn,
  output rate_strobe_t         strb,
  output logic [PRE_W-1:0]     pre1,
  output logic [PRE_W-1:0]     pre2,
  output logic [DIV_W-1:0]     divVal,
  output logic [OS_W-1:0]      osVal
);
  logic [CFG_W-1:0]     baudQ;
  logic [CFG_W-1:0]     osQ;
  logic [ALT_IDX_W-1:0] altIdx;
  logic                 useAlt;
  logic                 selEn;
  logic                 unusedCfg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baudQ <= '0;
      osQ   <= '0;
    end else begin
      if (baudWr) baudQ <= baudCfg;
      if (osWr)   osQ   <= osCfg;
    end
  end

  assign useAlt = baudQ[ALT_SEL_BIT];
  assign altIdx = baudQ[ALT_IDX_LSB +: ALT_IDX_W];
  assign pre1   = baudQ[PRE1_LSB +: PRE_W];
  assign pre2   = baudQ[PRE2_LSB +: PRE_W];
  assign divVal = baudQ[DIV_LSB +: DIV_W];
  assign osVal  = osQ[OS_W-1:0];

  assign selEn        = useAlt ? altEn[altIdx] : xtalEn;
  assign strb.clear   = baudWr | osWr;
  assign strb.srcTick = selEn & ~strb.clear;

  assign unusedCfg = ^{baudQ[CFG_W-1:ALT_SEL_BIT+1], baudQ[PRE1_LSB-1+PRE_W+1],
                       osQ[CFG_W-1:OS_W]};

  // R8: a written baud word is held from the next cycle
  a_r8_baud_capture: assert property (@(posedge clk) disable iff (!rstN)
    baudWr |=> baudQ == $past(baudCfg));
  // R8: a written oversampling word is held from the next cycle
  a_r8_os_capture: assert property (@(posedge clk) disable iff (!rstN)
    osWr |=> osQ == $past(osCfg));
  // R5: with every source idle nothing is counted
  a_r5_idle_sources: assert property (@(posedge clk) disable iff (!rstN)
    (!xtalEn && altEn == '0) |-> !strb.srcTick);
endmodule

// File: rtl/rate_datapath.sv
module rate_datapath
  import uart_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rate_strobe_t     strb,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  input  logic [DIV_W-1:0] divVal,
  input  logic [OS_W-1:0]  osVal,
  output logic             sampleTick,
  output logic             bitTick
);
  logic [NUM_STAGES:0]   chainEn;
  logic [DIV_W-1:0]      stageSet [NUM_STAGES];
  logic [OS_W-1:0]       osEff;
  logic [OS_W-1:0]       osCount;
  logic                  osLast;
  logic                  sampleQ;
  logic                  bitQ;

  assign stageSet[0] = DIV_W'(pre1);
  assign stageSet[1] = DIV_W'(pre2);
  assign stageSet[2] = divVal;
  assign chainEn[0]  = strb.srcTick;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam int STAGE_MAX = (i < NUM_STAGES - 1) ? PRE_MAX : (2**DIV_W - 1);
    rate_div_stage #(.W(DIV_W), .MAXV(STAGE_MAX)) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strb.clear),
      .inEn   (chainEn[i]),
      .setting(stageSet[i]),
      .outEn  (chainEn[i+1])
    );
  end

  assign osEff  = (osVal == '0) ? OS_W'(OS_DEFAULT) : osVal;
  assign osLast = (osCount >= osEff - OS_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      osCount <= '0;
      sampleQ <= 1'b0;
      bitQ    <= 1'b0;
    end else begin
      sampleQ <= chainEn[NUM_STAGES];
      bitQ    <= chainEn[NUM_STAGES] & osLast;
      if (chainEn[NUM_STAGES]) osCount <= osLast ? '0 : osCount + OS_W'(1);
    end
  end

  assign sampleTick = sampleQ;
  assign bitTick    = bitQ;

  // R7: a bit tick never appears without a sample tick
  a_r7_bit_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);
  // R6: the sample counter stays below the oversampling factor
  a_r6_os_in_range: assert property (@(posedge clk) disable iff (!rstN)
    osCount < osEff);
  // R9: ticks are quiet right after a configuration write
  a_r9_quiet_after_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!sampleTick && !bitTick));
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import uart_rate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] baudCfg,
  input  logic        baudWr,
  input  logic [31:0] osCfg,
  input  logic        osWr,
  input  logic        xtalEn,
  input  logic [3:0]  altEn,
  output logic        sampleTick,
  output logic        bitTick
);
  rate_strobe_t     strb;
  logic [PRE_W-1:0] pre1;
  logic [PRE_W-1:0] pre2;
  logic [DIV_W-1:0] divVal;
  logic [OS_W-1:0]  osVal;

  rate_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .baudCfg(baudCfg),
    .baudWr (baudWr),
    .osCfg  (osCfg),
    .osWr   (osWr),
    .xtalEn (xtalEn),
    .altEn  (altEn),
    .strb   (strb),
    .pre1   (pre1),
    .pre2   (pre2),
    .divVal (divVal),
    .osVal  (osVal)
  );

  rate_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pre1      (pre1),
    .pre2      (pre2),
    .divVal    (divVal),
    .osVal     (osVal),
    .sampleTick(sampleTick),
    .bitTick   (bitTick)
  );

  // R1: ticks are low in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!sampleTick && !bitTick));
endmodule

// File: tb/uart_rate_gen_bench.sv
`timescale 1ns/1ps
module uart_rate_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baudCfg = '0;
  logic        baudWr = 1'b0;
  logic [31:0] osCfg = '0;
  logic        osWr = 1'b0;
  logic        xtalEn = 1'b0;
  logic [3:0]  altEn = '0;
  logic        sampleTick;
  logic        bitTick;

  int checks = 0;
  int failures = 0;
  int density = 100;
  bit done = 0;

  logic [31:0] mBaud = '0;
  logic [31:0] mOs = '0;
  int  srcCnt = 0;
  int  smpCnt = 0;
  bit  expS = 0;
  bit  expB = 0;
  bit  lastWr = 0;

  always #4 clk = ~clk;

  uart_rate_gen u_uart_rate_gen (
    .clk(clk), .rstN(rstN), .baudCfg(baudCfg), .baudWr(baudWr),
    .osCfg(osCfg), .osWr(osWr), .xtalEn(xtalEn), .altEn(altEn),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );

  function automatic int preEff(int v);
    return (v == 0) ? 1 : ((v > 6) ? 6 : v);
  endfunction

  function automatic int period();
    int d;
    d = int'(mBaud[9:0]);
    if (d == 0) d = 1;
    return preEff(int'(mBaud[17:15])) * preEff(int'(mBaud[14:12])) * d;
  endfunction

  function automatic int osFactor();
    return (mOs[5:0] == 0) ? 16 : int'(mOs[5:0]);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // one clock: compare due results, drive new inputs, advance the model
  task automatic cycle(input bit bw, input logic [31:0] bv,
                       input bit ow, input logic [31:0] ov, input string tag);
    bit sel;
    check(sampleTick, expS, {tag, " sample"});
    check(bitTick, expB, {tag, " bit (R7)"});
    if (lastWr) begin
      check(sampleTick, 1'b0, "R9 sample after write");
      check(bitTick, 1'b0, "R9 bit after write");
    end
    baudWr  = bw; baudCfg = bv;
    osWr    = ow; osCfg   = ov;
    xtalEn  = (($urandom % 100) < density);
    for (int k = 0; k < 4; k++) altEn[k] = (($urandom % 100) < density);
    expS = 0; expB = 0;
    if (bw || ow) begin
      srcCnt = 0; smpCnt = 0;
      if (bw) mBaud = bv;
      if (ow) mOs = ov;
      lastWr = 1;
    end else begin
      lastWr = 0;
      sel = mBaud[19] ? altEn[mBaud[11:10]] : xtalEn;
      if (sel) begin
        srcCnt++;
        if (srcCnt >= period()) begin
          srcCnt = 0; expS = 1; smpCnt++;
          if (smpCnt >= osFactor()) begin smpCnt = 0; expB = 1; end
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(0, baudCfg, 0, osCfg, tag);
  endtask

  task automatic wrBaud(input logic [31:0] v, input string tag);
    cycle(1, v, 0, osCfg, tag);
  endtask

  task automatic wrOs(input logic [31:0] v, input string tag);
    cycle(0, baudCfg, 1, v, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sampleTick, 1'b0, "R1 reset sample");
    check(bitTick, 1'b0, "R1 reset bit");

    density = 100; run(100, "R1 defaults 16x");
    density = 60;  run(200, "R1 defaults sparse");

    wrBaud(32'd5, "R8 write");
    wrOs(32'd3, "R8 write");
    run(300, "R3 div5 os3");
    wrBaud(32'd0, "R8 write");
    wrOs(32'd1, "R8 write");
    density = 100; run(50, "R3 div0 os1");

    wrBaud((32'd2 << 15) | (32'd3 << 12) | 32'd2, "R8 write");
    wrOs(32'd4, "R8 write");
    density = 80; run(400, "R4 pre2 pre3");
    wrBaud((32'd7 << 15) | (32'd0 << 12) | 32'd3, "R8 write");
    density = 100; run(300, "R4 pre7 clamps");
    wrBaud((32'd6 << 15) | (32'd6 << 12) | 32'd1, "R8 write");
    wrOs(32'd2, "R8 write");
    run(400, "R4 pre6 pre6");

    wrBaud((32'd1 << 19) | (32'd2 << 10) | 32'd4, "R8 write");
    density = 50; run(600, "R5 alt index 2");
    wrBaud((32'd1 << 19) | (32'd3 << 10) | 32'd1, "R8 write");
    run(400, "R5 alt index 3");
    wrBaud((32'd0 << 19) | (32'd3 << 10) | 32'd2, "R8 write");
    run(400, "R5 xtal with index set");

    wrBaud(32'd1, "R8 write");
    wrOs(32'hFFFF_FFC5, "R8 write");
    density = 100; run(200, "R6 upper bits ignored os5");
    wrOs(32'd63, "R8 write");
    run(300, "R6 os63");
    wrOs(32'd0, "R8 write");
    run(100, "R6 os0 means 16");

    wrBaud(32'd3, "R8 write");
    wrOs(32'd5, "R8 write");
    for (int j = 0; j < 20; j++) begin
      density = 70;
      run(7 + j, "R8 mid-stream");
      if (j % 2 == 0) wrBaud(32'(1 + j % 4), "R8 rewrite baud");
      else            wrOs(32'(2 + j % 3), "R8 rewrite os");
    end
    run(100, "R2 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule